// File: doc/BRIEF.md
# Time-of-Day Access Control

This block sits beside the time-of-day counter of a peripheral and decides when that counter may advance and what value a bus master sees when it reads it. Writing the low byte of the counter turns counting on. Writing the high byte turns it off, and reset also leaves it off. Counting therefore stays halted until software writes the low byte, which lets software load the upper bytes before the clock starts again.

Reading the high byte freezes a snapshot of the counter. The snapshot stays in place until the low byte is read. A read that starts at the high byte and ends at the low byte therefore returns bytes from one instant, even if a count edge arrives between the accesses. Any access made while the alarm bank is selected leaves both controls unchanged, because that access goes to the alarm registers. The block holds the binary counter itself. The counter advances once for each rising edge reported by an upstream pin edge detector, and only while counting is enabled.

The interface has only plain control and status pins, with no streaming data path, so the ports carry no valid/ready handshake.

Top module: `tod_access_ctl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `cnt_en` and `rd_hold` are 0, `cnt_strobe_n` is 1 and `rd_value` is 0.
- R2: A low-byte write sets `cnt_en` to 1 from the next cycle onward. A low-byte write is `wr_n`=0, `tod_sel`=1, `reg_addr`=0 and `alarm_bank`=0, sampled at a rising clock edge.
- R3: A high-byte write clears `cnt_en` to 0 from the next cycle onward. A high-byte write is `wr_n`=0, `tod_sel`=1, `reg_addr`=2 and `alarm_bank`=0. If a set and a clear of the same flag arrive in one cycle, the clear wins.
- R4: `cnt_strobe_n` is 0 exactly in the cycles where `cnt_en`=1, `pin_edge`=1 and `pin_edge` was 0 in the previous cycle. At each clock edge in such a cycle the counter increments by one, modulo 2^CNT_W.
- R5: If `pin_edge` stays high for several cycles, the strobe fires at most once, in the first of those cycles.
- R6: A high-byte read sets `rd_hold` from the next cycle onward. A high-byte read is `rd_n`=0, `tod_sel`=1, `reg_addr`=2 and `alarm_bank`=0. While `rd_hold` is set, `rd_value` holds the counter value seen during the read cycle, even if counting continues.
- R7: A low-byte read clears `rd_hold` from the next cycle onward. A low-byte read is `rd_n`=0, `tod_sel`=1, `reg_addr`=0 and `alarm_bank`=0.
- R8: When `alarm_bank`=1, no read or write changes `cnt_en` or `rd_hold`.
- R9: Accesses with `tod_sel`=0, or with `reg_addr` equal to 1 or 3, change neither flag.
- R10: While `rd_hold` is 0, `rd_value` equals the live counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| tod_sel | input | 1 | Time-of-day register group selected |
| reg_addr | input | 2 | Byte index: 0 low, 1 middle, 2 high |
| alarm_bank | input | 1 | Control bit that steers accesses to the alarm registers |
| pin_edge | input | 1 | Pulse from the pin edge detector |
| cnt_strobe_n | output | 1 | Count strobe, active low |
| cnt_en | output | 1 | Counting enabled |
| rd_value | output | CNT_W | Value presented to the bus for reads |
| rd_hold | output | 1 | Read snapshot frozen |

## Verification
The bench sweeps every combination of the strobes, select, byte index, alarm bit and edge input in two orders. It then applies a long pseudo-random sequence and a counter wrap on an 8-bit configuration.

The sweep targets these failure modes:
- **Alarm bank not honoured:** a design that ignores the alarm bit would stop or start the clock on alarm writes.
- **Byte index decoded loosely:** a design that decodes too few address bits would treat middle-byte accesses as low or high.
- **Level-sensitive strobe:** a design that strobes on the level of `pin_edge` instead of its rise would count a long pulse several times.
- **Snapshot taken late:** a snapshot captured one cycle late would show a value that counted after the high-byte read, and a multi-byte read would tear.

// File: rtl/tod_ctl_pkg.sv
package tod_ctl_pkg;
  // Byte positions inside the time-of-day group; decoding depends on them.
  localparam int unsigned ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] LO_IDX = 2'd0;
  localparam logic [ADDR_W-1:0] HI_IDX = 2'd2;

  typedef struct packed {
    logic lo_wr;
    logic hi_wr;
    logic lo_rd;
    logic hi_rd;
  } tod_req_t;
endpackage

// File: rtl/tod_acc_decode.sv
module tod_acc_decode
  import tod_ctl_pkg::*;
(
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              tod_sel,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              alarm_bank,
  output tod_req_t          req_o
);
  logic grp_ok;
  logic is_lo;
  logic is_hi;

  always_comb begin
    grp_ok = tod_sel & ~alarm_bank;
    is_lo  = (reg_addr == LO_IDX);
    is_hi  = (reg_addr == HI_IDX);
    req_o.lo_wr = grp_ok & ~wr_n & is_lo;
    req_o.hi_wr = grp_ok & ~wr_n & is_hi;
    req_o.lo_rd = grp_ok & ~rd_n & is_lo;
    req_o.hi_rd = grp_ok & ~rd_n & is_hi;
  end
endmodule

// File: rtl/tod_srflag.sv
module tod_srflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);
  assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_o);
  assert_idle_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/tod_count_core.sv
module tod_count_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             edge_i,
  output logic             strobe_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  logic edge_q;

  assign strobe_o = en_i & edge_i & ~edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      cnt_o  <= '0;
    end else begin
      edge_q <= edge_i;
      if (strobe_o) cnt_o <= cnt_o + ONE;
    end
  end

  assert_strobe_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> en_i);
  assert_increment_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> (cnt_o == $past(cnt_o) + ONE));
  assert_no_strobe_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |=> $stable(cnt_o));
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/tod_read_hold.sv
module tod_read_hold #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] live_i,
  output logic [CNT_W-1:0] value_o
);
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (!hold_i) snap_q <= live_i;
  end

  assign value_o = hold_i ? snap_q : live_i;

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && $past(hold_i)) |-> $stable(value_o));
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i) |=> (hold_i -> (value_o == $past(live_i))));
endmodule

// File: rtl/tod_access_ctl.sv
module tod_access_ctl
  import tod_ctl_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             tod_sel,
  input  logic [1:0]       reg_addr,
  input  logic             alarm_bank,
  input  logic             pin_edge,
  output logic             cnt_strobe_n,
  output logic             cnt_en,
  output logic [CNT_W-1:0] rd_value,
  output logic             rd_hold
);
  tod_req_t         req;
  logic             strobe;
  logic [CNT_W-1:0] live_cnt;

  tod_acc_decode u_dec (
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .tod_sel    (tod_sel),
    .reg_addr   (reg_addr),
    .alarm_bank (alarm_bank),
    .req_o      (req)
  );

  tod_srflag u_en_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (req.lo_wr),
    .clr_i (req.hi_wr),
    .q_o   (cnt_en)
  );

  tod_srflag u_hold_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (req.hi_rd),
    .clr_i (req.lo_rd),
    .q_o   (rd_hold)
  );

  tod_count_core #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (cnt_en),
    .edge_i   (pin_edge),
    .strobe_o (strobe),
    .cnt_o    (live_cnt)
  );

  tod_read_hold #(.CNT_W(CNT_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (rd_hold),
    .live_i  (live_cnt),
    .value_o (rd_value)
  );

  assign cnt_strobe_n = ~strobe;

  assert_alarm_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_bank |=> ($stable(cnt_en) && $stable(rd_hold)));
  assert_unselected_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tod_sel || reg_addr == 2'd1 || reg_addr == 2'd3) |=> ($stable(cnt_en) && $stable(rd_hold)));
  assert_hi_write_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && tod_sel && !alarm_bank && reg_addr == 2'd2) |=> !cnt_en);
  assert_lo_read_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && tod_sel && !alarm_bank && reg_addr == 2'd0) |=> !rd_hold);
  assert_strobe_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_strobe_n |-> (cnt_en && pin_edge));
endmodule

// File: tb/tod_access_ctl_tb_top.sv
module tod_access_ctl_tb_top;
  localparam int unsigned CW = 8;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1, tod_sel = 1'b0, alarm_bank = 1'b0, pin_edge = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic cnt_strobe_n, cnt_en, rd_hold;
  logic [CW-1:0] rd_value;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic m_en = 1'b0, m_hold = 1'b0, m_prev = 1'b0;
  logic [CW-1:0] m_cnt = '0, m_snap = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  tod_access_ctl #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .tod_sel(tod_sel),
    .reg_addr(reg_addr), .alarm_bank(alarm_bank), .pin_edge(pin_edge),
    .cnt_strobe_n(cnt_strobe_n), .cnt_en(cnt_en), .rd_value(rd_value), .rd_hold(rd_hold)
  );

  task automatic chk(input string req, input string what, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one cycle, compare outputs, then advance the reference.
  task automatic step(input logic r, input logic w, input logic s, input logic [1:0] a,
                      input logic al, input logic e, input string tag);
    logic strobe, grp, lw, hw, lr, hr;
    @(negedge clk);
    rd_n = r; wr_n = w; tod_sel = s; reg_addr = a; alarm_bank = al; pin_edge = e;
    #2;
    strobe = m_en & e & ~m_prev;
    chk({tag, "/R4"}, "cnt_strobe_n", {{(CW-1){1'b0}}, cnt_strobe_n}, {{(CW-1){1'b0}}, ~strobe});
    chk({tag, "/R2R3"}, "cnt_en", {{(CW-1){1'b0}}, cnt_en}, {{(CW-1){1'b0}}, m_en});
    chk({tag, "/R6R7"}, "rd_hold", {{(CW-1){1'b0}}, rd_hold}, {{(CW-1){1'b0}}, m_hold});
    chk(m_hold ? {tag, "/R6"} : {tag, "/R10"}, "rd_value", rd_value, m_hold ? m_snap : m_cnt);
    @(posedge clk);
    grp = s & ~al;
    lw = grp & ~w & (a == 2'd0);
    hw = grp & ~w & (a == 2'd2);
    lr = grp & ~r & (a == 2'd0);
    hr = grp & ~r & (a == 2'd2);
    if (!m_hold) m_snap = m_cnt;
    if (strobe) m_cnt = m_cnt + ONE;
    if (hw) m_en = 1'b0; else if (lw) m_en = 1'b1;
    if (lr) m_hold = 1'b0; else if (hr) m_hold = 1'b1;
    m_prev = e;
  endtask

  task automatic idle(input logic e, input string tag);
    step(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, e, tag);
  endtask

  initial begin
    #(10 * 190000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state, held in reset
    #23;
    chk("R1", "cnt_en", {{(CW-1){1'b0}}, cnt_en}, '0);
    chk("R1", "rd_hold", {{(CW-1){1'b0}}, rd_hold}, '0);
    chk("R1", "cnt_strobe_n", {{(CW-1){1'b0}}, cnt_strobe_n}, ONE);
    chk("R1", "rd_value", rd_value, '0);
    @(negedge clk); rst_n = 1'b1;
    idle(1'b1, "R1");

    // R2 then R5: enable, then a long pulse counts once
    step(1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, "R2");
    idle(1'b0, "R2");
    for (int i = 0; i < 5; i++) idle(1'b1, "R5");
    idle(1'b0, "R5");
    chk("R5", "count after long pulse", rd_value, ONE);

    // R6: freeze, count continues, value stays
    step(1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 6; i++) idle(i[0], "R6");
    chk("R6", "frozen value", rd_value, ONE);
    // R7: release shows the advanced count
    step(1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, "R7");
    idle(1'b0, "R7");
    chk("R7", "released value", rd_value, ONE + ONE + ONE + ONE);

    // R8: alarm-bank accesses inert
    step(1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, "R8");
    idle(1'b0, "R8");
    chk("R8", "cnt_en kept", {{(CW-1){1'b0}}, cnt_en}, ONE);
    chk("R8", "rd_hold kept", {{(CW-1){1'b0}}, rd_hold}, '0);

    // R9: middle byte and deselected accesses inert
    step(1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, "R9");
    idle(1'b0, "R9");
    chk("R9", "cnt_en kept", {{(CW-1){1'b0}}, cnt_en}, ONE);

    // R3: high write stops counting
    step(1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, "R3");
    idle(1'b1, "R3");
    idle(1'b0, "R3");
    chk("R3", "cnt_en cleared", {{(CW-1){1'b0}}, cnt_en}, '0);

    // exhaustive sweep of the 128 input combinations, two orders
    for (int p = 0; p < 2; p++)
      for (int v = 0; v < 128; v++) begin
        logic [6:0] x;
        x = (p == 0) ? v[6:0] : ~v[6:0];
        step(x[0], x[1], x[2], x[4:3], x[5], x[6], "SWEEP");
      end

    // pseudo-random run
    for (int k = 0; k < 3000; k++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      step(lfsr[0] | lfsr[7], lfsr[1] | lfsr[8], lfsr[2], lfsr[4:3], lfsr[5] & lfsr[9], lfsr[6], "RAND");
    end

    // R4: wrap of the counter
    step(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, "R4");
    for (int k = 0; k < 600; k++) idle(k[0], "R4");
    idle(1'b0, "R4");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule